// File: doc/BRIEF.md
# SMBus Controller Status Flag Unit

This block keeps the event status register of a two-wire (SMBus/I2C) controller. A separate bit-level bus engine performs the serial shifting, clock generation and address comparison. It reports what happens on the wire as single-cycle strobes: start and stop conditions together with the current bit slot, arbitration loss, the ninth-clock acknowledge, a successful address phase, own-address and general-call matches, and winning bus mastership. The engine also drives a level that gives the current transfer direction.

The unit turns these strobes into four sticky event flags that software clears by writing ones: bus error, missing acknowledge, stall after address, and address match. It also holds two read-only mode flags, master and transmit. It drives a level interrupt request from the stall and match flags when interrupts are enabled. When the optional stall mode is enabled, it holds the clock line low after a master has sent its address in transmit mode, and keeps it low until software clears the stall flag. When the module enable is low, every flag reads as zero and the unit ignores all events.

Top module: `smb_status_unit`

## Requirements
- R1: After reset the register reads 0, and `irq` and `scl_hold` are low.
- R2: A start or stop strobe sets the bus-error flag only when `bit_slot` lies in 2..9 (data bits two to eight and the acknowledge slot). Slots 0, 1 and 10 and above leave the flag clear.
- R3: An arbitration-loss strobe sets the bus-error flag.
- R4: The missing-acknowledge flag sets when the acknowledge strobe reports no acknowledge while `dir_tx` is 1. An acknowledge, or a missing acknowledge while receiving, leaves it clear.
- R5: The stall flag sets only when `stall_en` is 1, the master flag is 1, `dir_tx` is 1 and the address-sent strobe fires. `scl_hold` is high exactly while the stall flag is set.
- R6: An own-address match strobe or a general-call match strobe sets the match flag.
- R7: Writing 1 to an event-flag bit clears that flag, and writing 0 has no effect. If a set and a clear of the same flag land in the same cycle, the flag stays set.
- R8: `irq` is high exactly when `irq_en` is 1 and the stall or match flag is set. The bus-error and missing-acknowledge flags never raise it.
- R9: The master flag sets on a won-mastership strobe and clears on a stop or arbitration-loss strobe. When a set and a clear arrive together, the clear wins.
- R10: The transmit flag shows `dir_tx` one cycle later.
- R11: While `en` is 0 the register reads 0 and `irq` and `scl_hold` are low in that same cycle. All flags are cleared, and events arriving while disabled leave no trace after re-enable.
- R12: Register layout: bit 0 bus error, bit 1 missing acknowledge, bit 2 stall, bit 3 match, bit 4 master, bit 5 transmit, and all higher bits read 0. A write affects bits 0..3 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Module enable |
| stall_en | input | 1 | Enables stall after the address phase |
| irq_en | input | 1 | Enables the interrupt request |
| ev_start | input | 1 | Start or repeated-start condition strobe |
| ev_stop | input | 1 | Stop condition strobe |
| bit_slot | input | SLOT_W | Bit clock within the frame (1..8 data, 9 acknowledge, 0 idle) |
| ev_arb_lost | input | 1 | Arbitration-loss strobe |
| ev_ack | input | 1 | Ninth-clock acknowledge sampled |
| ack_nack | input | 1 | With ev_ack: 1 means no acknowledge |
| ev_addr_ok | input | 1 | Address byte sent and acknowledged |
| ev_own_match | input | 1 | Address after start matched own address |
| ev_gcall | input | 1 | Address after start was a general call |
| ev_master_won | input | 1 | Bus-master request succeeded |
| dir_tx | input | 1 | Transfer direction, 1 = transmit |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 4 | Write data, 1 clears the flag |
| rd_data | output | DATA_W | Register read value |
| irq | output | 1 | Interrupt request level |
| scl_hold | output | 1 | Request to hold the clock line low |

## Verification
Each event strobe is sampled at one rising edge. The flag it touches shows in `rd_data` right after that edge, and `irq` and `scl_hold` follow in the same cycle, because both are combinational from the flags. The enable and interrupt-enable inputs take effect on the outputs with no delay. The transmit flag trails `dir_tx` by exactly one edge. The bench drives inputs on falling edges and compares all three outputs against its reference model one time unit after every rising edge. Its directed checks sample at the falling edge that follows the strobe's edge, so each result is read in the first cycle it is due.

// File: rtl/smb_stat_pkg.sv
package smb_stat_pkg;
   localparam int NUM_EVT   = 4;
   localparam int IDX_BERR  = 0;
   localparam int IDX_NACK  = 1;
   localparam int IDX_STALL = 2;
   localparam int IDX_MATCH = 3;
   localparam int IDX_MAST  = 4;
   localparam int IDX_TX    = 5;
   localparam int NUM_BITS  = 6;

   typedef struct packed {
      logic start;
      logic stop;
      logic arb_lost;
      logic ack;
      logic nack;
      logic addr_ok;
      logic own_match;
      logic gcall;
      logic won;
   } smb_evt_t;

   typedef struct packed {
      logic master;
      logic tx;
   } smb_mode_t;
endpackage

// File: rtl/smb_w1c_flag.sv
module smb_w1c_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q_o <= 1'b0;
      else if (!en)     q_o <= 1'b0;
      else if (set_i)   q_o <= 1'b1;
      else if (clr_i)   q_o <= 1'b0;
   end
endmodule

// File: rtl/smb_evt_decode.sv
module smb_evt_decode
   import smb_stat_pkg::*;
#(
   parameter int SLOT_W    = 4,
   parameter int WIN_LO    = 2,
   parameter int WIN_HI    = 9,
   parameter bit HAS_STALL = 1'b1
) (
   input  smb_evt_t            evt,
   input  logic [SLOT_W-1:0]   bit_slot,
   input  logic                dir_tx,
   input  logic                stall_en,
   input  logic                master_q,
   output logic [NUM_EVT-1:0]  set_vec
);
   logic in_window;
   logic cond_seen;
   logic stall_set;

   assign in_window = (int'(bit_slot) >= WIN_LO) && (int'(bit_slot) <= WIN_HI);
   assign cond_seen = evt.start | evt.stop;

   generate
      if (HAS_STALL) begin : g_stall
         assign stall_set = stall_en & evt.addr_ok & master_q & dir_tx;
      end else begin : g_nostall
         logic unused_stall;
         assign unused_stall = stall_en ^ evt.addr_ok ^ master_q;
         assign stall_set    = 1'b0;
      end
   endgenerate

   always_comb begin
      set_vec            = '0;
      set_vec[IDX_BERR]  = (cond_seen & in_window) | evt.arb_lost;
      set_vec[IDX_NACK]  = evt.ack & evt.nack & dir_tx;
      set_vec[IDX_STALL] = stall_set;
      set_vec[IDX_MATCH] = evt.own_match | evt.gcall;
   end
endmodule

// File: rtl/smb_mode_track.sv
module smb_mode_track
   import smb_stat_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      en,
   input  smb_evt_t  evt,
   input  logic      dir_tx,
   output smb_mode_t mode_q
);
   logic drop_master;
   assign drop_master = evt.stop | evt.arb_lost;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
      end else if (!en) begin
         mode_q <= '0;
      end else begin
         mode_q.tx <= dir_tx;
         if (drop_master)     mode_q.master <= 1'b0;
         else if (evt.won)    mode_q.master <= 1'b1;
      end
   end
endmodule

// File: rtl/smb_stat_out.sv
module smb_stat_out
   import smb_stat_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic               en,
   input  logic               irq_en,
   input  logic [NUM_EVT-1:0] flags_q,
   input  smb_mode_t          mode_q,
   output logic [DATA_W-1:0]  rd_data,
   output logic               irq,
   output logic               scl_hold
);
   logic [NUM_BITS-1:0] packed_bits;

   always_comb begin
      packed_bits                   = '0;
      packed_bits[NUM_EVT-1:0]      = flags_q;
      packed_bits[IDX_MAST]         = mode_q.master;
      packed_bits[IDX_TX]           = mode_q.tx;
   end

   generate
      for (genvar b = 0; b < DATA_W; b++) begin : g_rd
         if (b < NUM_BITS) begin : g_live
            assign rd_data[b] = en & packed_bits[b];
         end else begin : g_zero
            assign rd_data[b] = 1'b0;
         end
      end
   endgenerate

   assign irq      = en & irq_en & (flags_q[IDX_STALL] | flags_q[IDX_MATCH]);
   assign scl_hold = en & flags_q[IDX_STALL];
endmodule

// File: rtl/smb_status_unit.sv
module smb_status_unit
   import smb_stat_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int SLOT_W    = 4,
   parameter int WIN_LO    = 2,
   parameter int WIN_HI    = 9,
   parameter bit HAS_STALL = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               stall_en,
   input  logic               irq_en,
   input  logic               ev_start,
   input  logic               ev_stop,
   input  logic [SLOT_W-1:0]  bit_slot,
   input  logic               ev_arb_lost,
   input  logic               ev_ack,
   input  logic               ack_nack,
   input  logic               ev_addr_ok,
   input  logic               ev_own_match,
   input  logic               ev_gcall,
   input  logic               ev_master_won,
   input  logic               dir_tx,
   input  logic               wr_en,
   input  logic [NUM_EVT-1:0] wr_data,
   output logic [DATA_W-1:0]  rd_data,
   output logic               irq,
   output logic               scl_hold
);
   localparam int SLOT_MAX = (1 << SLOT_W) - 1;

   generate
      if (DATA_W < NUM_BITS) begin : g_bad_width
         $error("DATA_W too small for the status layout");
      end
      if (WIN_LO > WIN_HI) begin : g_bad_window
         $error("bus-error window is empty");
      end
      if (WIN_HI > SLOT_MAX) begin : g_bad_slot
         $error("bus-error window exceeds slot range");
      end
   endgenerate

   smb_evt_t            evt;
   smb_mode_t           mode_q;
   logic [NUM_EVT-1:0]  set_vec;
   logic [NUM_EVT-1:0]  flags_q;

   always_comb begin
      evt.start     = ev_start;
      evt.stop      = ev_stop;
      evt.arb_lost  = ev_arb_lost;
      evt.ack       = ev_ack;
      evt.nack      = ack_nack;
      evt.addr_ok   = ev_addr_ok;
      evt.own_match = ev_own_match;
      evt.gcall     = ev_gcall;
      evt.won       = ev_master_won;
   end

   smb_evt_decode #(
      .SLOT_W(SLOT_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI), .HAS_STALL(HAS_STALL)
   ) i_decode (
      .evt(evt), .bit_slot(bit_slot), .dir_tx(dir_tx), .stall_en(stall_en),
      .master_q(mode_q.master), .set_vec(set_vec)
   );

   generate
      for (genvar f = 0; f < NUM_EVT; f++) begin : g_flag
         smb_w1c_flag i_flag (
            .clk(clk), .rst_n(rst_n), .en(en),
            .set_i(set_vec[f]), .clr_i(wr_en & wr_data[f]), .q_o(flags_q[f])
         );
      end
   endgenerate

   smb_mode_track i_mode (
      .clk(clk), .rst_n(rst_n), .en(en), .evt(evt), .dir_tx(dir_tx), .mode_q(mode_q)
   );

   smb_stat_out #(.DATA_W(DATA_W)) i_out (
      .en(en), .irq_en(irq_en), .flags_q(flags_q), .mode_q(mode_q),
      .rd_data(rd_data), .irq(irq), .scl_hold(scl_hold)
   );
endmodule

// File: rtl/smb_status_chk.sv
module smb_status_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic              irq_en,
   input logic              wr_en,
   input logic [3:0]        wr_data,
   input logic              ev_arb_lost,
   input logic              ev_stop,
   input logic [DATA_W-1:0] rd_data,
   input logic              irq,
   input logic              scl_hold
);
   AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (rd_data == '0 && !irq && !scl_hold)); // R11
   AST_ARB_SETS_BERR: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en) && en && $past(ev_arb_lost)) |-> rd_data[0]); // R3
   AST_MASTER_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en) && en && $past(ev_stop || ev_arb_lost)) |-> !rd_data[4]); // R9
   AST_NACK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en) && en && $past(rd_data[1]) && !$past(wr_en && wr_data[1])) |-> rd_data[1]); // R7
   AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (irq_en && (rd_data[2] || rd_data[3]))); // R8
   AST_HOLD_NEEDS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      scl_hold |-> rd_data[2]); // R5
   AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en) && en && $past(scl_hold) && !$past(wr_en && wr_data[2])) |-> scl_hold); // R5
endmodule

bind smb_status_unit smb_status_chk #(.DATA_W(DATA_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .irq_en(irq_en), .wr_en(wr_en),
   .wr_data(wr_data), .ev_arb_lost(ev_arb_lost), .ev_stop(ev_stop),
   .rd_data(rd_data), .irq(irq), .scl_hold(scl_hold)
);

// File: tb/test_smb_status_unit.sv
`timescale 1ns/1ps
module test_smb_status_unit;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0, stall_en = 1'b0, irq_en = 1'b0;
   logic ev_start = 1'b0, ev_stop = 1'b0, ev_arb_lost = 1'b0, ev_ack = 1'b0, ack_nack = 1'b0;
   logic ev_addr_ok = 1'b0, ev_own_match = 1'b0, ev_gcall = 1'b0, ev_master_won = 1'b0;
   logic dir_tx = 1'b0, wr_en = 1'b0;
   logic [3:0] bit_slot = '0;
   logic [3:0] wr_data = '0;
   logic [7:0] rd_data;
   logic irq, scl_hold;

   int checks = 0;
   int errors = 0;
   string cur_req = "R1";
   bit done = 1'b0;

   always #4 clk = ~clk;

   smb_status_unit i_smb_status_unit (
      .clk(clk), .rst_n(rst_n), .en(en), .stall_en(stall_en), .irq_en(irq_en),
      .ev_start(ev_start), .ev_stop(ev_stop), .bit_slot(bit_slot),
      .ev_arb_lost(ev_arb_lost), .ev_ack(ev_ack), .ack_nack(ack_nack),
      .ev_addr_ok(ev_addr_ok), .ev_own_match(ev_own_match), .ev_gcall(ev_gcall),
      .ev_master_won(ev_master_won), .dir_tx(dir_tx), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .irq(irq), .scl_hold(scl_hold)
   );

   // behavioural reference state
   int m_berr = 0, m_nack = 0, m_stall = 0, m_match = 0, m_mast = 0, m_tx = 0;

   always @(posedge clk) begin
      int nb, nn, ns, nm, nma;
      if (!rst_n || !en) begin
         m_berr = 0; m_nack = 0; m_stall = 0; m_match = 0; m_mast = 0; m_tx = 0;
      end else begin
         nb = m_berr; nn = m_nack; ns = m_stall; nm = m_match; nma = m_mast;
         if (wr_en && wr_data[0]) nb = 0;
         if (wr_en && wr_data[1]) nn = 0;
         if (wr_en && wr_data[2]) ns = 0;
         if (wr_en && wr_data[3]) nm = 0;
         if (((ev_start || ev_stop) && bit_slot >= 2 && bit_slot <= 9) || ev_arb_lost) nb = 1;
         if (ev_ack && ack_nack && dir_tx) nn = 1;
         if (stall_en && ev_addr_ok && m_mast == 1 && dir_tx) ns = 1;
         if (ev_own_match || ev_gcall) nm = 1;
         if (ev_master_won) nma = 1;
         if (ev_stop || ev_arb_lost) nma = 0;
         m_berr = nb; m_nack = nn; m_stall = ns; m_match = nm; m_mast = nma;
         m_tx = dir_tx ? 1 : 0;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      int exp_rd, exp_irq, exp_hold;
      #1;
      if (!done) begin
         exp_rd = en ? (m_berr | (m_nack << 1) | (m_stall << 2) | (m_match << 3)
                        | (m_mast << 4) | (m_tx << 5)) : 0;
         exp_irq  = (en && irq_en && (m_stall || m_match)) ? 1 : 0;
         exp_hold = (en && m_stall) ? 1 : 0;
         chk({cur_req, " model rd_data"}, int'(rd_data), exp_rd);
         chk({cur_req, " model irq"}, int'(irq), exp_irq);
         chk({cur_req, " model scl_hold"}, int'(scl_hold), exp_hold);
      end
   end

   task automatic tick(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic drop_events;
      ev_start = 0; ev_stop = 0; ev_arb_lost = 0; ev_ack = 0; ack_nack = 0;
      ev_addr_ok = 0; ev_own_match = 0; ev_gcall = 0; ev_master_won = 0;
      wr_en = 0; wr_data = '0; bit_slot = '0;
   endtask

   task automatic wr(input logic [3:0] v);
      wr_en = 1; wr_data = v; tick(); drop_events();
   endtask

   task automatic cond(input bit is_start, input int slot);
      if (is_start) ev_start = 1; else ev_stop = 1;
      bit_slot = 4'(slot); tick(); drop_events();
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      tick(3);
      cur_req = "R1";
      chk("R1 reset rd_data", int'(rd_data), 0);
      chk("R1 reset irq", int'(irq), 0);
      chk("R1 reset scl_hold", int'(scl_hold), 0);
      rst_n = 1; en = 1; tick();

      cur_req = "R2";
      cond(1, 0);  chk("R2 start slot0", int'(rd_data[0]), 0);
      cond(0, 1);  chk("R2 stop slot1", int'(rd_data[0]), 0);
      cond(1, 5);  chk("R2 start slot5", int'(rd_data[0]), 1);
      wr(4'b0001);
      cond(0, 9);  chk("R2 stop ack slot", int'(rd_data[0]), 1);
      wr(4'b0001);
      cond(1, 10); chk("R2 start slot10", int'(rd_data[0]), 0);
      cond(0, 2);  chk("R2 stop slot2", int'(rd_data[0]), 1);
      wr(4'b0001);

      cur_req = "R3";
      ev_arb_lost = 1; tick(); drop_events();
      chk("R3 arb loss", int'(rd_data[0]), 1);
      cur_req = "R7";
      wr(4'b0000); chk("R7 write zero keeps", int'(rd_data[0]), 1);
      wr(4'b1110); chk("R7 other bits keep", int'(rd_data[0]), 1);
      wr(4'b0001); chk("R7 write one clears", int'(rd_data[0]), 0);

      cur_req = "R9";
      ev_master_won = 1; tick(); drop_events();
      chk("R9 master set", int'(rd_data), 8'h10);
      cond(0, 0); chk("R9 stop drops master", int'(rd_data), 8'h00);
      ev_master_won = 1; tick(); drop_events();
      ev_arb_lost = 1; tick(); drop_events();
      chk("R9 arb drops master", int'(rd_data), 8'h01);
      ev_master_won = 1; ev_stop = 1; tick(); drop_events();
      chk("R9 clear wins", int'(rd_data[4]), 0);
      wr(4'b0001);

      cur_req = "R10";
      dir_tx = 1; tick();
      chk("R10 tx flag", int'(rd_data[5]), 1);

      cur_req = "R4";
      ev_ack = 1; ack_nack = 1; tick(); drop_events();
      chk("R4 nack in tx", int'(rd_data[1]), 1);
      wr(4'b0010);
      ev_ack = 1; ack_nack = 0; tick(); drop_events();
      chk("R4 ack no flag", int'(rd_data[1]), 0);
      dir_tx = 0; ev_ack = 1; ack_nack = 1; tick(); drop_events();
      chk("R4 nack in rx", int'(rd_data[1]), 0);

      cur_req = "R5";
      dir_tx = 1; ev_master_won = 1; tick(); drop_events();
      ev_addr_ok = 1; tick(); drop_events();
      chk("R5 stall disabled", int'(rd_data[2]), 0);
      stall_en = 1; ev_addr_ok = 1; tick(); drop_events();
      chk("R5 stall set", int'(rd_data[2]), 1);
      chk("R5 hold high", int'(scl_hold), 1);
      chk("R8 irq masked", int'(irq), 0);
      cur_req = "R8";
      irq_en = 1; tick();
      chk("R8 irq from stall", int'(irq), 1);
      cur_req = "R5";
      tick(3);
      chk("R5 hold stays", int'(scl_hold), 1);
      wr(4'b0100);
      chk("R5 hold released", int'(scl_hold), 0);
      cond(0, 0);
      ev_addr_ok = 1; tick(); drop_events();
      chk("R5 no stall as slave", int'(rd_data[2]), 0);
      dir_tx = 0;

      cur_req = "R6";
      ev_own_match = 1; tick(); drop_events();
      chk("R6 own match", int'(rd_data[3]), 1);
      chk("R8 irq from match", int'(irq), 1);
      wr(4'b1000);
      ev_gcall = 1; tick(); drop_events();
      chk("R6 general call", int'(rd_data[3]), 1);
      cur_req = "R8";
      irq_en = 0; tick();
      chk("R8 irq off", int'(irq), 0);
      wr(4'b1000);
      irq_en = 1; ev_arb_lost = 1; tick(); drop_events();
      chk("R8 berr no irq", int'(irq), 0);
      wr(4'b0001);

      cur_req = "R7";
      ev_own_match = 1; wr_en = 1; wr_data = 4'b1000; tick(); drop_events();
      chk("R7 set beats clear", int'(rd_data[3]), 1);
      wr(4'b1000);

      cur_req = "R12";
      ev_arb_lost = 1; ev_own_match = 1; tick(); drop_events();
      chk("R12 layout", int'(rd_data), 8'h09);

      cur_req = "R11";
      stall_en = 1; dir_tx = 1; ev_master_won = 1; tick(); drop_events();
      ev_addr_ok = 1; tick(); drop_events();
      chk("R11 pre-disable hold", int'(scl_hold), 1);
      en = 0; #1;
      chk("R11 rd zero same cycle", int'(rd_data), 0);
      chk("R11 hold low same cycle", int'(scl_hold), 0);
      chk("R11 irq low same cycle", int'(irq), 0);
      tick();
      ev_arb_lost = 1; ev_own_match = 1; tick(); drop_events();
      dir_tx = 0; en = 1; #1;
      chk("R11 nothing after re-enable", int'(rd_data), 0);
      tick(2);
      chk("R11 still clear", int'(rd_data), 0);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule